// File: doc/BRIEF.md
# Ultra-Low-Power Wakeup Detector

This block watches three board-level inputs while the bus clock is stopped and only a slow always-on clock runs. The inputs are a lid-open signal, a power-button signal that is active low, and an AC-adapter-present signal. When one of them makes a transition into its active level and then stays active for its own programmable debounce time, the block latches a per-source wakeup status bit. It also sets a summary flag for an ultra-low-power wakeup and raises a wakeup request toward the power controller.

Software arms the detector with an enable level before the system sleeps. After the bus clock returns, software reads the status and clears it with a request level. The enable and clear levels come from the bus domain and cross through two-flop synchronisers. The three debounce thresholds are held steady by software while the detector is enabled, so they are used without synchronisation. The pins are asynchronous and are also synchronised.

Top module: `ulp_wake_det`

## Requirements
- R1: After reset, `wake_status_o`, `ulp_wake_o` and `wake_req_o` are all 0.
- R2: A rising transition on `ac_present_i` sets `wake_status_o[0]` if the pin then stays high for at least `thr_ac_i`+2 clock cycles, counting the first high cycle.
- R3: A rising transition on `lid_open_i` sets `wake_status_o[1]` under the same rule, using `thr_lid_i`.
- R4: A falling transition on `pwr_btn_n_i` (a press) sets `wake_status_o[2]` if the pin stays low for at least `thr_btn_i`+2 cycles.
- R5: A pulse that returns to the inactive level after only threshold+1 cycles sets no status; the source goes back to idle.
- R6: Only a transition into the active level starts a debounce. An input that is already active when the detector is enabled produces no event.
- R7: `ulp_wake_o` is set in the cycle after any source's detection and stays set until a clear.
- R8: `wake_req_o` is 1 exactly when the detector is enabled and at least one status bit is set. While the detector is disabled it is held at 0, and the status bits keep their values.
- R9: Clearing the enable in the middle of a debounce aborts it, and that pulse produces no status even if it continues.
- R10: A rising edge of the synchronised `clr_req_i` clears all status bits and `ulp_wake_o`. A detection in the same cycle still sets its bit.
- R11: A status bit stays set after its input returns to the inactive level, until a clear.
- R12: Each source uses only its own threshold. The same pulse length can pass one source's debounce and fail another's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on slow clock |
| rst_aon | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Detector enable level from the bus domain (synchronised) |
| clr_req_i | input | 1 | Status clear request level; its rising edge clears (synchronised) |
| thr_ac_i | input | CNT_W | AC-present debounce threshold |
| thr_lid_i | input | CNT_W | Lid-open debounce threshold |
| thr_btn_i | input | CNT_W | Power-button debounce threshold |
| ac_present_i | input | 1 | AC adapter present, active high, asynchronous |
| lid_open_i | input | 1 | Lid open, active high, asynchronous |
| pwr_btn_n_i | input | 1 | Power button, active low, asynchronous |
| wake_status_o | output | 3 | Sticky per-source status: bit 0 AC, bit 1 lid, bit 2 button |
| ulp_wake_o | output | 1 | Sticky flag that an ultra-low-power wakeup occurred |
| wake_req_o | output | 1 | Wakeup request, high while enabled and any status is set |

## Verification
The hardest situations to reach from the ports are the ones where an input is active but must not count. One is an input that is already active at the moment of enabling. The other is an input that stays active across a disable and re-enable in the middle of its debounce. The bench builds both by moving the enable level while holding the pin steady. It then waits well past the threshold and checks that no status appears. The debounce boundary is hit exactly by driving pulses of threshold+1 and threshold+2 clock cycles. Two sources with different thresholds receive the same pulse length, so that only one of them fires.

// File: rtl/ulp_wake_pkg.sv
package ulp_wake_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HOLD  = 2'd2
  } dbnc_st_e;

  localparam int SRC_AC  = 0;
  localparam int SRC_LID = 1;
  localparam int SRC_BTN = 2;
  localparam int NUM_SRC = 3;
endpackage

// File: rtl/ulp_sync2.sv
module ulp_sync2 #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ulp_dbnc_fsm.sv
module ulp_dbnc_fsm
  import ulp_wake_pkg::*;
#(
  parameter int   CNT_W   = 16,
  parameter logic ACT_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             detect_o
);
  logic             act;
  logic             act_prev_q;
  dbnc_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign act = ACT_LOW ? ~pin_i : pin_i;

  // Previous level tracks even while disabled, so enabling on an
  // already-active input gives no edge.
  always_ff @(posedge clk) begin
    if (rst) act_prev_q <= 1'b1;
    else     act_prev_q <= act;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!en_i) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (act && !act_prev_q) begin
            st_d  = ST_COUNT;
            cnt_d = '0;
          end
        end
        ST_COUNT: begin
          if (!act) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else if (cnt_q == thr_i) begin
            st_d = ST_HOLD;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (!act) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end
        end
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign detect_o = en_i && (st_q == ST_COUNT) && act && (cnt_q == thr_i);
endmodule

// File: rtl/ulp_wake_det.sv
module ulp_wake_det
  import ulp_wake_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_aon,
  input  logic             rst_aon,
  input  logic             enable_i,
  input  logic             clr_req_i,
  input  logic [CNT_W-1:0] thr_ac_i,
  input  logic [CNT_W-1:0] thr_lid_i,
  input  logic [CNT_W-1:0] thr_btn_i,
  input  logic             ac_present_i,
  input  logic             lid_open_i,
  input  logic             pwr_btn_n_i,
  output logic [2:0]       wake_status_o,
  output logic             ulp_wake_o,
  output logic             wake_req_o
);
  localparam logic [NUM_SRC-1:0] PIN_RST  = NUM_SRC'(1) << SRC_BTN;
  localparam logic [NUM_SRC-1:0] ACT_LOWV = NUM_SRC'(1) << SRC_BTN;

  logic [NUM_SRC-1:0] pin_raw, pin_s;
  logic [1:0]         ctl_s;
  logic               en_s, clr_s, clr_prev_q, clr_pulse;
  logic [CNT_W-1:0]   thr [NUM_SRC];
  logic [NUM_SRC-1:0] detect;
  logic [NUM_SRC-1:0] status_q, status_d;
  logic               ulp_q, ulp_d, req_q, req_d;

  assign pin_raw[SRC_AC]  = ac_present_i;
  assign pin_raw[SRC_LID] = lid_open_i;
  assign pin_raw[SRC_BTN] = pwr_btn_n_i;
  assign thr[SRC_AC]      = thr_ac_i;
  assign thr[SRC_LID]     = thr_lid_i;
  assign thr[SRC_BTN]     = thr_btn_i;

  ulp_sync2 #(.W(NUM_SRC), .RST_VAL(PIN_RST)) u_pin_sync (
    .clk(clk_aon), .rst(rst_aon), .d_i(pin_raw), .q_o(pin_s)
  );

  ulp_sync2 #(.W(2), .RST_VAL(2'b00)) u_ctl_sync (
    .clk(clk_aon), .rst(rst_aon), .d_i({clr_req_i, enable_i}), .q_o(ctl_s)
  );

  assign en_s  = ctl_s[0];
  assign clr_s = ctl_s[1];

  always_ff @(posedge clk_aon) begin
    if (rst_aon) clr_prev_q <= 1'b0;
    else         clr_prev_q <= clr_s;
  end

  assign clr_pulse = clr_s && !clr_prev_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    ulp_dbnc_fsm #(.CNT_W(CNT_W), .ACT_LOW(ACT_LOWV[g])) u_fsm (
      .clk(clk_aon), .rst(rst_aon), .en_i(en_s),
      .pin_i(pin_s[g]), .thr_i(thr[g]), .detect_o(detect[g])
    );
  end

  always_comb begin
    status_d = (status_q & ~{NUM_SRC{clr_pulse}}) | detect;
    ulp_d    = (ulp_q && !clr_pulse) || (|detect);
    req_d    = en_s && (|status_d);
  end

  always_ff @(posedge clk_aon) begin
    if (rst_aon) begin
      status_q <= '0;
      ulp_q    <= 1'b0;
      req_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      ulp_q    <= ulp_d;
      req_q    <= req_d;
    end
  end

  assign wake_status_o = status_q;
  assign ulp_wake_o    = ulp_q;
  assign wake_req_o    = req_q;
endmodule

// File: rtl/ulp_wake_chk.sv
module ulp_wake_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         en_s,
  input logic         clr_pulse,
  input logic [N-1:0] detect,
  input logic [N-1:0] status,
  input logic         ulp,
  input logic         req
);
  // R8
  req_off_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !en_s |=> !req);

  // R8
  req_needs_status_chk: assert property (@(posedge clk) disable iff (rst)
    req |-> (status != '0));

  // R11
  status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_pulse |=> ((status & $past(status)) == $past(status)));

  // R7
  ulp_on_detect_chk: assert property (@(posedge clk) disable iff (rst)
    (detect != '0) |=> ulp);

  // R10
  detect_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (detect != '0) |=> ((status & $past(detect)) == $past(detect)));

  // R10
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_pulse && detect == '0) |=> (status == '0 && !ulp));

  // R9
  no_detect_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !en_s |-> (detect == '0));
endmodule

bind ulp_wake_det ulp_wake_chk #(.N(3)) u_chk (
  .clk(clk_aon), .rst(rst_aon), .en_s(en_s), .clr_pulse(clr_pulse),
  .detect(detect), .status(status_q), .ulp(ulp_q), .req(req_q)
);

// File: tb/sim_ulp_wake_det.sv
module sim_ulp_wake_det;
  localparam int CNT_W = 16;
  localparam logic [CNT_W-1:0] THR_AC  = 16'd4;
  localparam logic [CNT_W-1:0] THR_LID = 16'd12;
  localparam logic [CNT_W-1:0] THR_BTN = 16'd7;

  logic clk = 1'b0;
  logic rst, en, clr, ac, lid, btn_n;
  logic [2:0] status;
  logic ulp, req;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  ulp_wake_det #(.CNT_W(CNT_W)) u0 (
    .clk_aon(clk), .rst_aon(rst), .enable_i(en), .clr_req_i(clr),
    .thr_ac_i(THR_AC), .thr_lid_i(THR_LID), .thr_btn_i(THR_BTN),
    .ac_present_i(ac), .lid_open_i(lid), .pwr_btn_n_i(btn_n),
    .wake_status_o(status), .ulp_wake_o(ulp), .wake_req_o(req)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input int idx, input bit active);
    if (idx == 0) ac = active;
    else if (idx == 1) lid = active;
    else btn_n = !active;
  endtask

  task automatic pulse(input int idx, input int len);
    @(negedge clk);
    set_pin(idx, 1'b1);
    wait_clk(len);
    set_pin(idx, 1'b0);
    wait_clk(6);
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    wait_clk(4);
    clr = 1'b0;
    wait_clk(3);
  endtask

  task automatic t_reset();
    check(status == 3'b000, "R1 status", status, 0);
    check(ulp == 1'b0, "R1 ulp", ulp, 0);
    check(req == 1'b0, "R1 req", req, 0);
  endtask

  task automatic t_ac();
    pulse(0, THR_AC + 2);
    check(status == 3'b001, "R2 ac status", status, 1);
    check(ulp == 1'b1, "R7 ulp after ac", ulp, 1);
    check(req == 1'b1, "R8 req while enabled", req, 1);
    wait_clk(10);
    check(status == 3'b001, "R11 sticky after release", status, 1);
    do_clear();
    check(status == 3'b000 && ulp == 1'b0, "R10 clear", {ulp, status}, 0);
    check(req == 1'b0, "R8 req after clear", req, 0);
  endtask

  task automatic t_lid();
    pulse(1, THR_LID + 2);
    check(status == 3'b010, "R3 lid status", status, 2);
    do_clear();
  endtask

  task automatic t_btn();
    pulse(2, THR_BTN + 2);
    check(status == 3'b100, "R4 button press status", status, 4);
    check(ulp == 1'b1, "R7 ulp after button", ulp, 1);
    do_clear();
  endtask

  task automatic t_short();
    pulse(0, THR_AC + 1);
    check(status == 3'b000, "R5 short ac pulse", status, 0);
    pulse(2, THR_BTN + 1);
    check(status == 3'b000 && ulp == 1'b0, "R5 short button pulse", {ulp, status}, 0);
  endtask

  task automatic t_level_enable();
    @(negedge clk); en = 1'b0;
    wait_clk(4);
    set_pin(1, 1'b1);
    wait_clk(4);
    en = 1'b1;
    wait_clk(THR_LID + 10);
    check(status == 3'b000, "R6 already active at enable", status, 0);
    set_pin(1, 1'b0);
    wait_clk(4);
  endtask

  task automatic t_disable_mid();
    @(negedge clk); set_pin(0, 1'b1);
    wait_clk(3);
    en = 1'b0;
    wait_clk(6);
    en = 1'b1;
    wait_clk(THR_AC + 10);
    set_pin(0, 1'b0);
    wait_clk(4);
    check(status == 3'b000, "R9 aborted debounce", status, 0);
  endtask

  task automatic t_req_disabled();
    pulse(2, THR_BTN + 5);
    check(req == 1'b1, "R8 req set", req, 1);
    @(negedge clk); en = 1'b0;
    wait_clk(4);
    check(req == 1'b0, "R8 req held low when disabled", req, 0);
    check(status == 3'b100, "R8 status kept while disabled", status, 4);
    en = 1'b1;
    wait_clk(4);
    check(req == 1'b1, "R8 req back on enable", req, 1);
    do_clear();
  endtask

  task automatic t_independent();
    @(negedge clk);
    set_pin(0, 1'b1);
    set_pin(1, 1'b1);
    wait_clk(8);
    set_pin(0, 1'b0);
    set_pin(1, 1'b0);
    wait_clk(6);
    check(status == 3'b001, "R12 same pulse, different thresholds", status, 1);
    do_clear();
  endtask

  initial begin
    wait_clk(100000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; en = 1'b0; clr = 1'b0;
    ac = 1'b0; lid = 1'b0; btn_n = 1'b1;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    t_reset();
    en = 1'b1;
    wait_clk(4);
    t_ac();
    t_lid();
    t_btn();
    t_short();
    t_level_enable();
    t_disable_mid();
    t_req_disabled();
    t_independent();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule